// File: doc/BRIEF.md
# Scan-Chain Debug Port

This block lets a host reach into a small processor over four wires. It acts as a serial slave that moves a 64-bit frame through a scan register. A separately pulsed processor clock then commits that frame into shadow registers. The shadow registers can force an instruction and an immediate operand into the processor, and can raise a memory write-enable. The same scan register also returns a 64-bit status snapshot to the host. The processor supplies that snapshot, and it is loaded in parallel at the start of every frame.

All host lines are asynchronous to the block's system clock. Each one goes through a two-flop synchronizer, and edges are detected in the system clock domain. The host must hold each level of the serial clock and of the processor clock for at least four system clock cycles. A full exchange runs in this order: one capture pulse, then 64 shift pulses, then one pulse of the processor clock. The first pulse after the processor clock goes low, or after reset, only captures status and shifts nothing. The frame that follows is sent with its top byte (index 7) first and each byte most significant bit first.

Top module: `scan_debug_port`

## Requirements
- R1: A synchronous active-high reset clears the force flag, the write-enable, the instruction and immediate outputs and the scan register, so `miso_o` reads 0. After reset the next serial clock pulse is a capture pulse.
- R2: On each rising serial clock edge that is not a capture, the scan register shifts left by one and takes the synchronized `mosi_i` into bit 0. After 64 such pulses, byte k of the frame sits in bits [8k+7:8k], and byte 7 is the byte that was sent first.
- R3: The first rising serial clock edge after a falling processor clock edge, or after reset, loads `status_i` into the scan register. `mosi_i` is ignored on that pulse and nothing shifts.
- R4: `miso_o` always shows bit 63 of the scan register. The captured status therefore comes back most significant bit first, one bit per serial clock period, and the host reads each bit during the low phase that comes before the next shift.
- R5: The force flag, instruction, immediate and write-enable outputs change only on a rising processor clock edge. They hold their values while a frame is being shifted.
- R6: On a rising processor clock edge, if byte 7 of the scan register equals 0x02, `force_o` becomes 1, `instr_o` takes byte 1 and `imm_o` takes byte 0.
- R7: On a rising processor clock edge, if byte 7 is any other value, `force_o` and `wr_en_o` become 0, and `instr_o` and `imm_o` keep their previous values.
- R8: On a commit with byte 7 equal to 0x02, `wr_en_o` becomes 1 if byte 1 equals 0x02 and 0 otherwise. A memory write therefore takes one frame to raise write-enable and a second frame to drop it.
- R9: The status returned in a frame is the value of `status_i` at its capture pulse. Later changes to `status_i` during that frame have no effect on it.
- R10: `wr_en_o` is never 1 while `force_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial clock from the host (asynchronous) |
| mosi_i | input | 1 | Serial data from the host (asynchronous) |
| miso_o | output | 1 | Serial readback data to the host |
| cpu_clk_i | input | 1 | Processor clock pulse from the host (asynchronous) |
| status_i | input | 64 | Parallel processor status, captured at frame start |
| force_o | output | 1 | Force the processor to take `instr_o` as its instruction |
| instr_o | output | 8 | Forced instruction byte |
| imm_o | output | 8 | Forced immediate byte |
| wr_en_o | output | 1 | Memory write-enable |

## Verification
The assertions check on every cycle the rules that hold between edge events. The shadow outputs stay frozen unless a processor clock rise was detected. The scan register changes only on a serial clock rise. A capture pulse lands exactly the status seen one cycle earlier and clears the pending capture. Write-enable never appears without force. Only the bench scenarios can show the end-to-end serial behaviour: bit and byte order across a whole frame, readback of many status patterns including every single-bit position, the hold rule for frames that are not forced, the two-frame write sequence, and how the block behaves after a reset in the middle of a run.

// File: rtl/sdp_pkg.sv
package sdp_pkg;
   localparam int unsigned SDP_BYTE_W = 8;
   typedef logic [SDP_BYTE_W-1:0] sdp_byte_t;

   // edge polarity selector for the edge detector
   typedef enum logic { SDP_EDGE_FALL = 1'b0, SDP_EDGE_RISE = 1'b1 } sdp_edge_e;
endpackage

// File: rtl/sdp_sync.sv
module sdp_sync #(
   parameter int unsigned WIDTH  = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] chain [STAGES];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int s = 0; s < int'(STAGES); s++) chain[s] <= '0;
      end else begin
         chain[0] <= d;
         for (int s = 1; s < int'(STAGES); s++) chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/sdp_edge.sv
module sdp_edge
   import sdp_pkg::*;
#(
   parameter sdp_edge_e POLARITY = SDP_EDGE_RISE
) (
   input  logic clk,
   input  logic rst,
   input  logic level,
   output logic hit
);
   logic prev;

   always_ff @(posedge clk) begin
      if (rst) prev <= 1'b0;
      else     prev <= level;
   end

   generate
      if (POLARITY == SDP_EDGE_RISE) begin : g_rise
         assign hit = level & ~prev;
      end else begin : g_fall
         assign hit = ~level & prev;
      end
   endgenerate
endmodule

// File: rtl/sdp_scan.sv
module sdp_scan #(
   parameter int unsigned FRAME_W = 64
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               step,
   input  logic               ser_in,
   input  logic               arm,
   input  logic [FRAME_W-1:0] par_in,
   output logic [FRAME_W-1:0] chain,
   output logic               pending
);
   always_ff @(posedge clk) begin
      if (rst) begin
         chain   <= '0;
         pending <= 1'b1;
      end else begin
         if (step) begin
            if (pending) chain <= par_in;
            else         chain <= {chain[FRAME_W-2:0], ser_in};
         end
         if (arm)       pending <= 1'b1;
         else if (step) pending <= 1'b0;
      end
   end
endmodule

// File: rtl/sdp_shadow.sv
module sdp_shadow
   import sdp_pkg::*;
#(
   parameter sdp_byte_t FORCE_CODE = 8'h02,
   parameter sdp_byte_t WE_CODE    = 8'h02
) (
   input  logic      clk,
   input  logic      rst,
   input  logic      commit,
   input  sdp_byte_t ctl_byte,
   input  sdp_byte_t op_byte,
   input  sdp_byte_t val_byte,
   output logic      force_q,
   output logic      wr_en_q,
   output sdp_byte_t instr_q,
   output sdp_byte_t imm_q
);
   logic forced;
   assign forced = (ctl_byte == FORCE_CODE);

   always_ff @(posedge clk) begin
      if (rst) begin
         force_q <= 1'b0;
         wr_en_q <= 1'b0;
         instr_q <= '0;
         imm_q   <= '0;
      end else if (commit) begin
         force_q <= forced;
         wr_en_q <= forced && (op_byte == WE_CODE);
         if (forced) begin
            instr_q <= op_byte;
            imm_q   <= val_byte;
         end
      end
   end
endmodule

// File: rtl/scan_debug_port.sv
module scan_debug_port
   import sdp_pkg::*;
#(
   parameter int unsigned FRAME_BYTES = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned CTL_SLOT    = 7,
   parameter int unsigned OP_SLOT     = 1,
   parameter int unsigned VAL_SLOT    = 0,
   parameter sdp_byte_t   FORCE_CODE  = 8'h02,
   parameter sdp_byte_t   WE_CODE     = 8'h02,
   localparam int unsigned FRAME_W    = FRAME_BYTES * SDP_BYTE_W
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               sclk_i,
   input  logic               mosi_i,
   output logic               miso_o,
   input  logic               cpu_clk_i,
   input  logic [FRAME_W-1:0] status_i,
   output logic               force_o,
   output logic [7:0]         instr_o,
   output logic [7:0]         imm_o,
   output logic               wr_en_o
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("scan_debug_port: SYNC_STAGES must be at least 2");
      end
      if (FRAME_BYTES < 3) begin : g_bad_frame
         $error("scan_debug_port: FRAME_BYTES must be at least 3");
      end
      if (CTL_SLOT >= FRAME_BYTES || OP_SLOT >= FRAME_BYTES || VAL_SLOT >= FRAME_BYTES) begin : g_bad_slot
         $error("scan_debug_port: byte slot outside the frame");
      end
   endgenerate

   // synchronized host lines: [2]=serial clock, [1]=processor clock, [0]=data
   logic [2:0] host_q;
   sdp_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst (rst),
      .d   ({sclk_i, cpu_clk_i, mosi_i}),
      .q   (host_q)
   );

   logic sclk_rise, cpu_rise, cpu_fall;
   sdp_edge #(.POLARITY(SDP_EDGE_RISE)) u_sclk_rise (
      .clk(clk), .rst(rst), .level(host_q[2]), .hit(sclk_rise));
   sdp_edge #(.POLARITY(SDP_EDGE_RISE)) u_cpu_rise (
      .clk(clk), .rst(rst), .level(host_q[1]), .hit(cpu_rise));
   sdp_edge #(.POLARITY(SDP_EDGE_FALL)) u_cpu_fall (
      .clk(clk), .rst(rst), .level(host_q[1]), .hit(cpu_fall));

   logic [FRAME_W-1:0] scan;
   logic               pend;
   sdp_scan #(.FRAME_W(FRAME_W)) u_scan (
      .clk     (clk),
      .rst     (rst),
      .step    (sclk_rise),
      .ser_in  (host_q[0]),
      .arm     (cpu_fall),
      .par_in  (status_i),
      .chain   (scan),
      .pending (pend)
   );

   assign miso_o = scan[FRAME_W-1];

   sdp_shadow #(.FORCE_CODE(FORCE_CODE), .WE_CODE(WE_CODE)) u_shadow (
      .clk      (clk),
      .rst      (rst),
      .commit   (cpu_rise),
      .ctl_byte (scan[CTL_SLOT*SDP_BYTE_W +: SDP_BYTE_W]),
      .op_byte  (scan[OP_SLOT*SDP_BYTE_W +: SDP_BYTE_W]),
      .val_byte (scan[VAL_SLOT*SDP_BYTE_W +: SDP_BYTE_W]),
      .force_q  (force_o),
      .wr_en_q  (wr_en_o),
      .instr_q  (instr_o),
      .imm_q    (imm_o)
   );
endmodule

// File: rtl/sdp_checker.sv
module sdp_checker #(
   parameter int unsigned FRAME_W = 64
) (
   input logic               clk,
   input logic               rst,
   input logic               sclk_rise,
   input logic               cpu_rise,
   input logic               cpu_fall,
   input logic               pend,
   input logic [FRAME_W-1:0] scan,
   input logic [FRAME_W-1:0] status_i,
   input logic               force_o,
   input logic               wr_en_o,
   input logic [7:0]         instr_o,
   input logic [7:0]         imm_o
);
   assert_reset_clears_R1: assert property (@(posedge clk)
      rst |=> (!force_o && !wr_en_o && instr_o == 8'h00 && imm_o == 8'h00 && scan == '0 && pend));

   assert_scan_moves_on_sclk_R2: assert property (@(posedge clk) disable iff (rst)
      !sclk_rise |=> $stable(scan));

   assert_capture_loads_status_R3: assert property (@(posedge clk) disable iff (rst)
      (sclk_rise && pend) |=> (scan == $past(status_i)));

   assert_capture_once_R3: assert property (@(posedge clk) disable iff (rst)
      (sclk_rise && pend && !cpu_fall) |=> !pend);

   assert_shadow_hold_R5: assert property (@(posedge clk) disable iff (rst)
      !cpu_rise |=> ($stable(force_o) && $stable(wr_en_o) && $stable(instr_o) && $stable(imm_o)));

   assert_we_needs_force_R10: assert property (@(posedge clk) disable iff (rst)
      wr_en_o |-> force_o);
endmodule

bind scan_debug_port sdp_checker #(.FRAME_W(FRAME_W)) u_sdp_checker (
   .clk       (clk),
   .rst       (rst),
   .sclk_rise (sclk_rise),
   .cpu_rise  (cpu_rise),
   .cpu_fall  (cpu_fall),
   .pend      (pend),
   .scan      (scan),
   .status_i  (status_i),
   .force_o   (force_o),
   .wr_en_o   (wr_en_o),
   .instr_o   (instr_o),
   .imm_o     (imm_o)
);

// File: tb/tb_scan_debug_port.sv
module tb_scan_debug_port;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        sclk_i = 1'b0;
   logic        mosi_i = 1'b0;
   logic        cpu_clk_i = 1'b0;
   logic [63:0] status_i = '0;
   logic        miso_o, force_o, wr_en_o;
   logic [7:0]  instr_o, imm_o;

   int compared = 0;
   int mismatched = 0;

   // expected shadow state, modelled from the requirements
   logic       e_force = 1'b0, e_we = 1'b0;
   logic [7:0] e_instr = '0, e_imm = '0;

   always #5 clk = ~clk;

   scan_debug_port dut (
      .clk(clk), .rst(rst), .sclk_i(sclk_i), .mosi_i(mosi_i), .miso_o(miso_o),
      .cpu_clk_i(cpu_clk_i), .status_i(status_i), .force_o(force_o),
      .instr_o(instr_o), .imm_o(imm_o), .wr_en_o(wr_en_o)
   );

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic chk_shadow(input string req);
      chk(req, {63'd0, force_o}, {63'd0, e_force});
      chk(req, {63'd0, wr_en_o}, {63'd0, e_we});
      chk(req, {56'd0, instr_o}, {56'd0, e_instr});
      chk(req, {56'd0, imm_o},   {56'd0, e_imm});
   endtask

   // one serial clock period: data changes mid-low, readback sampled in low phase
   task automatic sclk_bit(input logic b, output logic rx);
      sclk_i = 1'b0;
      wait_clk(4);
      mosi_i = b;
      rx = miso_o;
      wait_clk(4);
      sclk_i = 1'b1;
      wait_clk(8);
      sclk_i = 1'b0;
   endtask

   // capture pulse (MOSI held 1, must be ignored: R3), 64 shifts, processor clock pulse
   task automatic run_frame(input logic [63:0] tx, input logic [63:0] stat);
      logic [63:0] rx;
      logic        dummy;
      status_i = stat;
      sclk_bit(1'b1, dummy);
      status_i = ~stat;                 // R9: later status change must not matter
      for (int i = 63; i >= 0; i--) begin
         sclk_bit(tx[i], rx[i]);
         if (i == 32) chk_shadow("R5 hold during shift");
      end
      wait_clk(4);
      chk("R4 R9 readback", rx, stat);
      cpu_clk_i = 1'b1;
      wait_clk(8);
      cpu_clk_i = 1'b0;
      wait_clk(8);
      // model R6 R7 R8
      if (tx[63:56] == 8'h02) begin
         e_force = 1'b1;
         e_instr = tx[15:8];
         e_imm   = tx[7:0];
         e_we    = (tx[15:8] == 8'h02);
      end else begin
         e_force = 1'b0;
         e_we    = 1'b0;
      end
      chk_shadow("R2 R6 R7 R8 commit");
      chk("R10 we implies force", {63'd0, wr_en_o & ~force_o}, 64'd0);
   endtask

   initial begin
      wait_clk(5);
      rst = 1'b0;
      wait_clk(2);
      chk_shadow("R1 reset state");
      chk("R1 miso after reset", {63'd0, miso_o}, 64'd0);

      // instruction sweep, some frames not forced (byte 7 = 0x03)
      for (int k = 0; k < 14; k++) begin
         logic [7:0]  op;
         logic [7:0]  ctl;
         logic [63:0] tx;
         case (k % 7)
            0: op = 8'hA4; 1: op = 8'hA8; 2: op = 8'hAC; 3: op = 8'hC4;
            4: op = 8'hC8; 5: op = 8'h02; default: op = 8'h00;
         endcase
         ctl = (k % 4 == 3) ? 8'h03 : 8'h02;
         tx  = {ctl, 40'h0, op, 8'(k * 37 + 5)};
         tx[47:24] = 24'(k * 24'h1357);  // filler bytes, must not affect outputs
         run_frame(tx, 64'h0123_4567_89AB_CDEF ^ (64'(k) * 64'h1111_1111_1111_1111));
      end

      // two-frame write: raise then drop write-enable (R8)
      run_frame({8'h02, 40'h0, 8'h02, 8'h00}, 64'hFFFF_0000_FFFF_0000);
      chk("R8 we raised", {63'd0, wr_en_o}, 64'd1);
      run_frame({8'h02, 40'h0, 8'h00, 8'h00}, 64'h0000_FFFF_0000_FFFF);
      chk("R8 we dropped", {63'd0, wr_en_o}, 64'd0);

      // raise write-enable then a non-forced frame clears it (R7)
      run_frame({8'h02, 40'h0, 8'h02, 8'h77}, 64'h5555_AAAA_5555_AAAA);
      run_frame({8'h00, 40'h0, 8'hAC, 8'h11}, 64'hAAAA_5555_AAAA_5555);
      chk("R7 we cleared", {63'd0, wr_en_o}, 64'd0);

      // walking-one readback sweep over every bit position (R4), not forced
      for (int j = 0; j < 64; j++) begin
         run_frame({8'h00, 48'h0, 8'(j)}, 64'd1 << j);
      end

      // reset in the middle of a run (R1)
      run_frame({8'h02, 40'h0, 8'hA8, 8'h3C}, 64'hDEAD_BEEF_0BAD_F00D);
      rst = 1'b1;
      wait_clk(3);
      rst = 1'b0;
      wait_clk(2);
      e_force = 1'b0; e_we = 1'b0; e_instr = '0; e_imm = '0;
      chk_shadow("R1 reset mid run");
      chk("R1 miso cleared", {63'd0, miso_o}, 64'd0);
      run_frame({8'h02, 40'h0, 8'hC4, 8'h99}, 64'h8000_0000_0000_0001);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      compared++;
      mismatched++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule